// File: doc/BRIEF.md
# System-Control Register Bank with Compare Timer

This block holds the control and status registers of a 64-bit RISC core's system-control coprocessor. The core moves a value in with a write request (valid, 5-bit register number, 64-bit data) and reads a register combinationally through a separate read port. Only the low 32 bits of written data are used. Each register applies its own write mask. Some registers discard writes. Some writes have side effects on neighbouring state.

Alongside the plain registers the bank keeps a 32-bit cycle counter, a compare value, a replacement-slot counter that steps down on each retired instruction, and a pending timer bit. An illegal access is reported on a one-cycle error flag. The timer interrupt request is a combination of the pending bit and two status bits.

Top module: `sysctl_regbank`

## Requirements
- R1: A write stores `data[31:0] & mask` for the selected register. The masks are: number 0 `0x8000003F`, numbers 2 and 3 `0x3FFFFFFF`, number 5 `0x01FFE000`, number 10 `0xFFFFE0FF`, number 28 `0x0FFFFFC0`. Numbers 6, 12, 14, 16, 18 and 19 keep all 32 bits. `data[63:32]` is ignored.
- R2: A write to number 4 replaces bits 31:23 with the written value, retains bits 22:4, and leaves bits 3:0 zero.
- R3: Writes to numbers 1, 8, 15 and 27 leave those registers unchanged. Number 29 reads zero after any write.
- R4: `err` is high in the cycle after any of these writes, and low otherwise: a write to a number outside {0–6, 8–16, 18, 19, 27–29}; a write to number 0 whose `data[5:0]` exceeds `TLB_ENTRIES-1` (the masked value is still stored); a write of nonzero 64-bit data to number 13.
- R5: Number 13 holds only its bit 15 (the timer pending bit). A write of zero clears it. A nonzero write leaves it unchanged.
- R6: `rd_data` equals the 32-bit register selected by `rd_sel`, sign-extended from bit 31, with no clock delay. Unimplemented numbers read zero.
- R7: Number 9 increments by one, modulo 2^32, on each cycle with `tick` high. A write to number 9 loads the written value and takes precedence over a tick in the same cycle.
- R8: A tick that makes number 9 equal to number 11 sets bit 15 of number 13. The bit stays set until number 11 is written or number 13 is written with zero. Such a clearing write takes precedence over a match in the same cycle.
- R9: A write to number 6 sets number 1 to `TLB_ENTRIES-1` in the next cycle, even if `retire` is high in the same cycle.
- R10: On each `retire` pulse, number 1 decrements by one. If it is already at or below number 6, it returns to `TLB_ENTRIES-1` instead.
- R11: `timer_irq` = bit 15 of number 13 AND bit 15 of number 12 AND bit 0 of number 12.
- R12: After reset, all registers read zero except number 1, which reads `TLB_ENTRIES-1`. `err` and `timer_irq` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write request valid |
| wr_sel | input | 5 | Register number to write |
| wr_data | input | 64 | Write data (low 32 bits used) |
| rd_sel | input | 5 | Register number to read |
| rd_data | output | 64 | Sign-extended read value |
| tick | input | 1 | Counter increment enable |
| retire | input | 1 | Instruction-retire pulse for the replacement counter |
| err | output | 1 | Illegal-access flag, one cycle after the write |
| timer_irq | output | 1 | Timer interrupt request |

## Verification
The bench uses the default `TLB_ENTRIES` of 32, so the replacement counter's full 31-to-floor walk is short enough to step through entirely. The index legality limit then sits at bit-pattern 31, right inside the 6-bit field.

All 32 register numbers are swept with three data patterns, and every register is read back after each write. This covers every mask, every ignored slot, and every error case. Directed sequences then cover:
- a counter match and a counter wrap onto the compare value;
- the precedence of a clearing write over a same-cycle match;
- the precedence of a counter load over a same-cycle tick;
- replacement-counter wraps at several floor values.

// File: rtl/sysctl_pkg.sv
// Package: register numbers and per-register write behaviour of the
// system-control register bank. Assumes 32-bit register storage.
package sysctl_pkg;
    localparam int REG_W = 32;
    localparam int SEL_W = 5;
    localparam int NREG  = 1 << SEL_W;

    localparam int N_INDEX   = 0;
    localparam int N_RANDOM  = 1;
    localparam int N_CONTEXT = 4;
    localparam int N_WIRED   = 6;
    localparam int N_COUNT   = 9;
    localparam int N_COMPARE = 11;
    localparam int N_STATUS  = 12;
    localparam int N_CAUSE   = 13;

    localparam int PEND_BIT = 15;

    // Whether a register number is implemented.
    function automatic logic is_known(input int sel);
        case (sel)
            0, 1, 2, 3, 4, 5, 6, 8, 9, 10, 11, 12, 13, 14, 15, 16,
            18, 19, 27, 28, 29: is_known = 1'b1;
            default:            is_known = 1'b0;
        endcase
    endfunction

    // Bits taken from the written value.
    function automatic logic [REG_W-1:0] take_mask(input int sel);
        case (sel)
            0:                      take_mask = 32'h8000_003F;
            2, 3:                   take_mask = 32'h3FFF_FFFF;
            4:                      take_mask = 32'hFF80_0000;
            5:                      take_mask = 32'h01FF_E000;
            10:                     take_mask = 32'hFFFF_E0FF;
            28:                     take_mask = 32'h0FFF_FFC0;
            6, 12, 14, 16, 18, 19:  take_mask = 32'hFFFF_FFFF;
            default:                take_mask = '0;
        endcase
    endfunction

    // Bits retained from the old value on a write.
    function automatic logic [REG_W-1:0] hold_mask(input int sel);
        case (sel)
            4:             hold_mask = 32'h007F_FFF0;
            8, 15, 27:     hold_mask = 32'hFFFF_FFFF;
            default:       hold_mask = '0;
        endcase
    endfunction
endpackage

// File: rtl/sysctl_slot.sv
// One plain register: on a write it keeps the masked new bits plus the
// retained old bits. Assumes SLOT is an implemented, non-special number.
module sysctl_slot
    import sysctl_pkg::*;
#(
    parameter int SLOT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [REG_W-1:0] wval,
    output logic [REG_W-1:0] q
);
    localparam logic [REG_W-1:0] TAKE = take_mask(SLOT);
    localparam logic [REG_W-1:0] HOLD = hold_mask(SLOT);

    // Register update: merge of masked write data and retained bits.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= (wval & TAKE) | (q & HOLD);
    end

    assert_slot_masked_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ((q & ~(TAKE | HOLD)) == '0));
endmodule

// File: rtl/sysctl_random.sv
// Replacement-slot counter: steps down per retire and wraps to TOP at
// or below the floor. A floor write reloads TOP. Assumes TOP < 2^REG_W.
module sysctl_random
    import sysctl_pkg::*;
#(
    parameter int TOP = 31
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic             step,
    input  logic [REG_W-1:0] floor_v,
    output logic [REG_W-1:0] q
);
    localparam logic [REG_W-1:0] TOPV = REG_W'(TOP);

    // Counter update: reload has priority over stepping.
    always_ff @(posedge clk) begin
        if (!rst_n)               q <= TOPV;
        else if (reload)          q <= TOPV;
        else if (step) begin
            if (q <= floor_v)     q <= TOPV;
            else                  q <= q - 1'b1;
        end
    end

    assert_reload_top_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> (q == TOPV));
    assert_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        q <= TOPV);
    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!reload && !step) |=> $stable(q));
endmodule

// File: rtl/sysctl_timer.sv
// Counter, compare value and timer pending bit. Assumes at most one of
// the write strobes is active in a cycle (they decode one number).
module sysctl_timer
    import sysctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic             cmp_wr,
    input  logic             pend_clr,
    input  logic [REG_W-1:0] wval,
    output logic [REG_W-1:0] cnt,
    output logic [REG_W-1:0] cmp,
    output logic             pend
);
    logic [REG_W-1:0] cnt_inc;
    assign cnt_inc = cnt + 1'b1;

    // Counter: load wins over increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (cnt_wr) cnt <= wval;
        else if (tick)   cnt <= cnt_inc;
    end

    // Compare value: plain load.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp <= '0;
        else if (cmp_wr) cmp <= wval;
    end

    // Pending bit: clearing writes win over a match.
    always_ff @(posedge clk) begin
        if (!rst_n)                               pend <= 1'b0;
        else if (cmp_wr || pend_clr)              pend <= 1'b0;
        else if (tick && !cnt_wr && cnt_inc == cmp) pend <= 1'b1;
    end

    assert_count_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && !tick) |=> $stable(cnt));
    assert_count_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> (cnt == $past(cnt) + 1'b1));
    assert_pend_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !cmp_wr && !pend_clr) |=> pend);
    assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_wr || pend_clr) |=> !pend);
endmodule

// File: rtl/sysctl_regbank.sv
// Top: system-control register bank. Decodes writes to per-register
// slots and the timer/replacement counters, and flags illegal writes.
// Assumes TLB_ENTRIES is between 2 and 64 (6-bit index field).
module sysctl_regbank
    import sysctl_pkg::*;
#(
    parameter int TLB_ENTRIES = 32,
    parameter int XLEN        = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [XLEN-1:0]  wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [XLEN-1:0]  rd_data,
    input  logic             tick,
    input  logic             retire,
    output logic             err,
    output logic             timer_irq
);
    localparam int IDX_W = 6;
    localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(TLB_ENTRIES - 1);

    logic [REG_W-1:0] view [NREG];
    logic [REG_W-1:0] wval;
    logic [REG_W-1:0] rnd_q, cnt_q, cmp_q;
    logic             pend_q;
    logic             bad_wr;
    logic             cause_zero;

    assign wval       = wr_data[REG_W-1:0];
    assign cause_zero = (wr_data == '0);

    // Illegal-access decode for the current write.
    always_comb begin
        bad_wr = 1'b0;
        if (wr_en) begin
            if (!is_known(int'(wr_sel)))
                bad_wr = 1'b1;
            else if (int'(wr_sel) == N_INDEX && wr_data[IDX_W-1:0] > IDX_MAX)
                bad_wr = 1'b1;
            else if (int'(wr_sel) == N_CAUSE && !cause_zero)
                bad_wr = 1'b1;
        end
    end

    // Error flag: one-cycle report of an illegal write.
    always_ff @(posedge clk) begin
        if (!rst_n) err <= 1'b0;
        else        err <= bad_wr;
    end

    genvar i;
    generate
        for (i = 0; i < NREG; i++) begin : g_reg
            if (i == N_RANDOM) begin : g_rnd
                assign view[i] = rnd_q;
            end else if (i == N_COUNT) begin : g_cnt
                assign view[i] = cnt_q;
            end else if (i == N_COMPARE) begin : g_cmp
                assign view[i] = cmp_q;
            end else if (i == N_CAUSE) begin : g_cause
                assign view[i] = REG_W'(pend_q) << PEND_BIT;
            end else if (is_known(i)) begin : g_plain
                sysctl_slot #(.SLOT(i)) u_slot (
                    .clk   (clk),
                    .rst_n (rst_n),
                    .hit   (wr_en && int'(wr_sel) == i),
                    .wval  (wval),
                    .q     (view[i])
                );
            end else begin : g_none
                assign view[i] = '0;
            end
        end
    endgenerate

    sysctl_random #(.TOP(TLB_ENTRIES - 1)) u_random (
        .clk     (clk),
        .rst_n   (rst_n),
        .reload  (wr_en && int'(wr_sel) == N_WIRED),
        .step    (retire),
        .floor_v (view[N_WIRED]),
        .q       (rnd_q)
    );

    sysctl_timer u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .cnt_wr   (wr_en && int'(wr_sel) == N_COUNT),
        .cmp_wr   (wr_en && int'(wr_sel) == N_COMPARE),
        .pend_clr (wr_en && int'(wr_sel) == N_CAUSE && cause_zero),
        .wval     (wval),
        .cnt      (cnt_q),
        .cmp      (cmp_q),
        .pend     (pend_q)
    );

    // Read path: sign-extend the selected register.
    always_comb begin
        rd_data = {{(XLEN-REG_W){view[rd_sel][REG_W-1]}}, view[rd_sel]};
    end

    // Interrupt request: pending AND mask AND global enable.
    always_comb begin
        timer_irq = view[N_CAUSE][PEND_BIT] & view[N_STATUS][PEND_BIT]
                  & view[N_STATUS][0];
    end

    assert_err_after_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(wr_en));
    assert_cause_nonzero_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_sel) == N_CAUSE && !cause_zero && !tick) |=> $stable(pend_q));
    assert_irq_needs_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        timer_irq |-> pend_q);
endmodule

// File: tb/sysctl_regbank_test.sv
module sysctl_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_sel = '0;
    logic [63:0] wr_data = '0;
    logic [4:0]  rd_sel = '0;
    logic [63:0] rd_data;
    logic        tick = 1'b0;
    logic        retire = 1'b0;
    logic        err;
    logic        timer_irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] m [32];
    logic        m_err;

    always #5 clk = ~clk;

    sysctl_regbank #(.TLB_ENTRIES(32), .XLEN(64)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .tick(tick), .retire(retire), .err(err), .timer_irq(timer_irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic known(input int s);
        return (s <= 6) || (s >= 8 && s <= 16) || s == 18 || s == 19 || (s >= 27 && s <= 29);
    endfunction

    // Reference model of one write (no tick, no retire).
    task automatic m_write(input int s, input logic [63:0] d);
        logic [31:0] v;
        v = d[31:0];
        m_err = 1'b0;
        case (s)
            0: begin m[0] = v & 32'h8000_003F; m_err = (d[5:0] > 6'd31); end
            2, 3: m[s] = v & 32'h3FFF_FFFF;
            4: m[4] = (v & 32'hFF80_0000) | (m[4] & 32'h007F_FFF0);
            5: m[5] = v & 32'h01FF_E000;
            6: begin m[6] = v; m[1] = 32'd31; end
            9, 11, 12, 14, 16, 18, 19: m[s] = v;
            10: m[10] = v & 32'hFFFF_E0FF;
            13: if (d == 0) m[13] = 0; else m_err = 1'b1;
            28: m[28] = v & 32'h0FFF_FFC0;
            29: m[29] = 0;
            1, 8, 15, 27: ;
            default: m_err = 1'b1;
        endcase
        if (s == 11) m[13] = 0;
    endtask

    task automatic wr(input int s, input logic [63:0] d, input string tag);
        wr_en = 1'b1; wr_sel = 5'(s); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        m_write(s, d);
        chk({tag, " err"}, 64'(err), 64'(m_err));
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        m[9] = m[9] + 1;
        if (m[9] == m[11]) m[13] = 32'h0000_8000;
    endtask

    task automatic do_retire();
        retire = 1'b1;
        @(negedge clk);
        retire = 1'b0;
        if (m[1] <= m[6]) m[1] = 31; else m[1] = m[1] - 1;
    endtask

    task automatic rd_all(input string tag);
        for (int r = 0; r < 32; r++) begin
            rd_sel = 5'(r);
            #1;
            chk(tag, rd_data, {{32{m[r][31]}}, m[r]});
        end
    endtask

    function automatic logic m_irq();
        return m[13][15] & m[12][15] & m[12][0];
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hang expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] pats [3];
        pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[1] = 64'h1234_0000_5A5A_5A05;
        pats[2] = 64'h0;
        for (int r = 0; r < 32; r++) m[r] = 0;
        m[1] = 31;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12 reset state
        rd_all("R12 reset read");
        chk("R12 reset err", 64'(err), 0);
        chk("R12 reset irq", 64'(timer_irq), 0);

        // R1 R2 R3 R4 R5 R6: sweep of all numbers and patterns
        for (int p = 0; p < 3; p++) begin
            for (int s = 0; s < 32; s++) begin
                wr(s, pats[p], known(s) ? "R4 legal write" : "R4 unlisted");
                rd_all("R1 R2 R3 R5 R6 sweep read");
            end
        end
        // R2 retained bits: bits 22:4 stay zero, 3:0 stay zero
        wr(4, 64'h0000_0000_0080_000F, "R2 ctx");
        rd_all("R2 context read");
        // R4 index at limit is legal, one above is not
        wr(0, 64'd31, "R4 index 31");
        wr(0, 64'd32, "R4 index 32");
        rd_all("R4 index stored");

        // R7 R8 R11 timer
        wr(12, 64'h8001, "R11 status");
        wr(11, 64'd5, "R8 cmp");
        wr(9, 64'd2, "R7 cnt");
        do_tick(); do_tick();
        rd_all("R7 count step");
        chk("R11 irq before match", 64'(timer_irq), 64'(m_irq()));
        do_tick();
        rd_all("R8 match sets pending");
        chk("R11 irq on", 64'(timer_irq), 1);
        do_tick(); do_tick();
        rd_all("R8 pending sticky");
        wr(12, 64'h8000, "R11 status no enable");
        chk("R11 irq masked by enable", 64'(timer_irq), 0);
        wr(12, 64'h0001, "R11 status no mask");
        chk("R11 irq masked by mask", 64'(timer_irq), 0);
        wr(12, 64'h8001, "R11 status both");
        chk("R11 irq back", 64'(timer_irq), 1);
        wr(13, 64'h1, "R5 cause nonzero");
        rd_all("R5 cause unchanged");
        wr(13, 64'h0, "R5 cause zero");
        rd_all("R5 cause cleared");
        chk("R11 irq off", 64'(timer_irq), 0);
        // R7 wrap onto compare value zero
        wr(11, 64'd0, "R8 cmp0");
        wr(9, 64'hFFFF_FFFF, "R7 cnt max");
        do_tick();
        rd_all("R7 wrap R8 match");
        // R8 compare write clears
        wr(11, 64'd100, "R8 cmp clr");
        rd_all("R8 compare clears");
        // R8 clearing write wins over a same-cycle match
        wr(9, 64'd99, "R8 cnt");
        wr_en = 1'b1; wr_sel = 5'd13; wr_data = 0; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        m[9] = 100; m[13] = 0;
        rd_all("R8 clear beats match");
        // R7 load beats tick
        wr_en = 1'b1; wr_sel = 5'd9; wr_data = 64'd7; tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; tick = 1'b0;
        m[9] = 7;
        rd_all("R7 load beats tick");

        // R9 R10 replacement counter
        wr(6, 64'd28, "R9 wired");
        rd_all("R9 reload");
        for (int k = 0; k < 5; k++) begin
            do_retire();
            rd_all("R10 step/wrap at floor 28");
        end
        wr(6, 64'd0, "R9 wired0");
        for (int k = 0; k < 34; k++) begin
            do_retire();
            rd_sel = 5'd1; #1;
            chk("R10 walk floor 0", rd_data, 64'(m[1]));
        end
        wr(6, 64'd40, "R9 wired big");
        do_retire();
        rd_sel = 5'd1; #1;
        chk("R10 floor above top", rd_data, 64'd31);
        wr(6, 64'd3, "R9 wired3");
        do_retire(); do_retire();
        wr_en = 1'b1; wr_sel = 5'd6; wr_data = 64'd3; retire = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; retire = 1'b0;
        rd_sel = 5'd1; #1;
        chk("R9 reload beats retire", rd_data, 64'd31);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule